// File: doc/BRIEF.md
# Oversampled Edge-Coincidence Vernier Counter

This block watches two free-running periodic inputs whose frequencies differ slightly, for example about 31.8 MHz and 30.0 MHz. Both inputs are treated as data and never as clocks. A single sampling clock, at least twice as fast as the faster input and ideally far faster, samples both through their own two-stage synchronizers. A rising edge on an input is a 0-to-1 change between two consecutive synchronized samples of that same input. A coincidence is a sampling period in which both inputs show a rising edge at the same time.

A start strobe clears the pulse counter and arms it. While armed, the counter advances once for each rising edge of input A. The first coincidence freezes the count, raises a done flag that stays high until the next start, and emits a single-cycle coincidence pulse. Because aligned edges recur at about the beat frequency of the two inputs, the frozen count is a vernier-style measure of the phase relation between the inputs. If no coincidence arrives, the counter holds at its maximum value and does not wrap.

Top module: `vernier_coinc_counter`

## Requirements
- R1: While reset is held, and after it is released, count is 0, done is 0 and coin_pulse is 0.
- R2: A rising edge is a 0-to-1 change between two successive synchronized samples of the same input. A level first sampled high at sampling edge k takes effect on the counter state at edge k+2.
- R3: While armed, count increases by one for each rising edge of sig_a. This includes the edge of sig_a that forms the coincidence.
- R4: If both inputs present a rising edge in the same sampling cycle while the counter is armed, coin_pulse is high for exactly one cycle, in the same cycle that done first goes high.
- R5: After a coincidence, count stays frozen and done stays high until the next start strobe, whatever edges the inputs show in the meantime.
- R6: If the count reaches 2^CNT_W-1 without a coincidence, it stays at that value and does not wrap.
- R7: A start strobe sampled at edge s leaves count 0, done 0 and the counter armed after edge s. In that cycle the start strobe takes priority over any edge or coincidence, which is then ignored.
- R8: Before the first start strobe after reset, edges and coincidences have no effect: count stays 0, done stays 0 and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; the only clock of the block |
| rst | input | 1 | Synchronous reset, active high |
| sig_a | input | 1 | First asynchronous periodic input; its rising edges are counted |
| sig_b | input | 1 | Second asynchronous periodic input |
| start | input | 1 | One-cycle strobe that clears and arms the counter |
| coin_pulse | output | 1 | One-cycle pulse on the first coincidence after start |
| done | output | 1 | High from the coincidence until the next start |
| count | output | CNT_W | Rising edges of sig_a counted since start |

## Verification
Two events can fall in the same sampling cycle: a start strobe and a coincidence, or a start strobe and a counted edge. The bench places the start exactly on the cycle in which an aligned pair of edges reaches the counter, and then one cycle later. A reference that knows only the driven waveforms and the two-cycle edge latency decides whether that pair is ignored or counted as an immediate coincidence with count 1. The frozen count, the done flag, the number of pulses and the cycle of the pulse are then compared against that reference, across random period and phase pairs and a case with equal periods that must saturate.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2
    } run_state_e;

    typedef struct packed {
        logic rise_a;
        logic rise_b;
    } edge_pair_t;

    function automatic logic both_rise(edge_pair_t e);
        return e.rise_a & e.rise_b;
    endfunction

endpackage

// File: rtl/vcc_edge_det.sv
module vcc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;

    // R2: an input needs at least two samples per period, so two rises are never back to back
    p_rise_gap_r2: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);

endmodule

// File: rtl/vcc_run_ctl.sv
module vcc_run_ctl
    import vcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  edge_pair_t       edges,
    output logic             coin_pulse,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             pulse_q;

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (start) begin
                state <= ST_ARMED;
                cnt   <= '0;
            end else if (state == ST_ARMED) begin
                if (edges.rise_a) cnt <= sat_inc(cnt);
                if (both_rise(edges)) begin
                    state   <= ST_DONE;
                    pulse_q <= 1'b1;
                end
            end
        end
    end

    assign coin_pulse = pulse_q;
    assign done       = (state == ST_DONE);
    assign count      = cnt;

    p_freeze_r5:    assert property (@(posedge clk) disable iff (rst) (done && !start) |=> ($stable(count) && done));
    p_no_wrap_r6:   assert property (@(posedge clk) disable iff (rst) (count == CNT_MAX && !start) |=> (count == CNT_MAX));
    p_start_clr_r7: assert property (@(posedge clk) disable iff (rst) start |=> (count == '0 && !done && !coin_pulse));
    p_pulse_one_r4: assert property (@(posedge clk) disable iff (rst) coin_pulse |=> !coin_pulse);
    p_pulse_done_r4: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> coin_pulse);
    p_idle_r8:      assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE) |=> (count == '0 || $past(start)));

endmodule

// File: rtl/vernier_coinc_counter.sv
module vernier_coinc_counter
    import vcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_a,
    input  logic             sig_b,
    input  logic             start,
    output logic             coin_pulse,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] rise_v;
    edge_pair_t     edges;

    assign raw_in = {sig_b, sig_a};

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            vcc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[i]),
                .rise (rise_v[i])
            );
        end
    endgenerate

    assign edges.rise_a = rise_v[0];
    assign edges.rise_b = rise_v[1];

    vcc_run_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .edges      (edges),
        .coin_pulse (coin_pulse),
        .done       (done),
        .count      (count)
    );

    // R1: nothing is flagged in the cycle after reset
    p_reset_r1: assert property (@(posedge clk) rst |=> (!done && !coin_pulse && count == '0));

endmodule

// File: tb/vernier_coinc_counter_tb.sv
module vernier_coinc_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_a = 1'b0;
    logic sig_b = 1'b0;
    logic start = 1'b0;
    logic coin_pulse, done;
    logic [CNT_W-1:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit prev_a = 1'b0;
    bit prev_b = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vernier_coinc_counter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .sig_a(sig_a), .sig_b(sig_b), .start(start),
        .coin_pulse(coin_pulse), .done(done), .count(count)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit lvl(int n, int ncyc, int p, int ph);
        int m;
        m = (n >= ncyc) ? ncyc - 1 : n;
        return ((m + ph) % p) < (p / 2);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        sig_a = 0; sig_b = 0; start = 0; rst = 1;
        prev_a = 0; prev_b = 0;
        repeat (4) @(negedge clk);
        check("R1 count in reset", int'(count), 0);
        check("R1 done in reset", int'(done), 0);
        rst = 0;
    endtask

    // s < 0 means no start strobe in this run
    task automatic run_case(string name, int pa, int pb, int pha, int phb, int s, int ncyc, bit rs);
        int mcnt = 0;
        bit mdone = 0;
        int nco = -1;
        int pulses = 0;
        int seen = -1;
        if (rs) do_reset();
        for (int n = 0; n < ncyc + 4; n++) begin
            bit a, b, ra, rb, arm;
            @(negedge clk);
            if (coin_pulse) begin pulses++; seen = n; end
            a = lvl(n, ncyc, pa, pha);
            b = lvl(n, ncyc, pb, phb);
            sig_a = a; sig_b = b;
            start = (n == s);
            ra = a & !prev_a;
            rb = b & !prev_b;
            prev_a = a; prev_b = b;
            arm = (s >= 0) && (n >= s - 1) && !mdone;
            if (arm && ra && mcnt < CMAX) mcnt++;
            if (arm && ra && rb) begin mdone = 1; nco = n; end
        end
        @(negedge clk);
        start = 0;
        if (coin_pulse) begin pulses++; seen = -2; end
        check($sformatf("R3/R5/R6 %s count", name), int'(count), mcnt);
        check($sformatf("R5/R8 %s done", name), int'(done), int'(mdone));
        check($sformatf("R4/R8 %s pulses", name), pulses, mdone ? 1 : 0);
        if (mdone) check($sformatf("R2/R4 %s pulse cycle", name), seen, nco + 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pa, pb, pha, phb, s;
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 pulse after reset", int'(coin_pulse), 0);
        // R8: no start, edges and coincidences ignored
        run_case("idle", 5, 7, 0, 0, -1, 120, 1);
        // R3 R4: basic beat, first coincidence at n=0 ignored before start
        run_case("beat", 5, 7, 0, 0, 3, 120, 1);
        // R7: start on the cycle the aligned pair at n=35 reaches the counter
        run_case("start_collide", 5, 7, 0, 0, 37, 120, 1);
        // R7 R3: start one cycle earlier, aligned pair counts at once
        run_case("start_before", 5, 7, 0, 0, 36, 120, 1);
        // R7 R5: restart without reset after done
        run_case("restart", 6, 9, 1, 4, 10, 150, 0);
        // R6: equal periods offset in phase never align
        run_case("saturate", 6, 6, 0, 3, 2, 500, 1);
        for (int k = 0; k < 12; k++) begin
            pa  = 4 + int'($urandom % 17);
            pb  = 4 + int'($urandom % 17);
            pha = int'($urandom % pa);
            phb = int'($urandom % pb);
            s   = int'($urandom % 40);
            run_case($sformatf("rand%0d", k), pa, pb, pha, phb, s, 500, (k % 3) != 2);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule